// File: doc/BRIEF.md
# Conditional Test Evaluator

This block decides whether the condition named by a conditional instruction holds. A 5-bit selector picks one test. The test may look at four arithmetic flags, at one of two loop counters, at a pseudorandom bit, at the result of a bit-pattern compare on an I/O port, or at the status of the last bit-manipulation operation. The result `cond_true` is combinational, so it is valid in the same cycle as the selector and its inputs.

Some tests have side effects. When one of them is evaluated with `eval_en` high, the block raises a strobe. For a counter test, that strobe increments the counter under test, after the comparison has used the old value. For a heads or tails test, it asks an outside pseudorandom generator to step.

Both loop counters are 16-bit two's-complement registers held inside the block. Each can be loaded through a shared value bus. The instruction decoder drives the selector. The arithmetic unit, the generator and the I/O port supply the flags.

Top module: `cond_eval`

## Requirements
- R1: Selector codes 2 to 7 test the sign and zero flags. Code 2 (pl) is true when `flag_neg` is clear. Code 3 (mi) is true when `flag_neg` is set. Code 4 (eq) is true when `flag_zero` is set. Code 5 (ne) is true when `flag_zero` is clear. Code 6 (gt) is true when both `flag_neg` and `flag_zero` are clear. Code 7 (le) is true when either flag is set.
- R2: Code 8 is true when `flag_lovf` is set and code 9 when it is clear. Code 10 is true when `flag_movf` is set and code 11 when it is clear.
- R3: Codes 12 and 13 test whether counter 0 is ≥ 0 or < 0. Codes 14 and 15 do the same for counter 1. The sign test reads the counter value present before any increment.
- R4: When `eval_en` is high and a code from 12 to 15 is selected, the counter under test grows by one at the next clock edge, wrapping from 0x7FFF to 0x8000 and from 0xFFFF to 0x0000. `cnt_inc[0]` marks counter 0 and `cnt_inc[1]` marks counter 1 in that cycle.
- R5: `ld0` or `ld1` writes `ld_val` into counter 0 or counter 1 at the next edge. A load wins over an increment in the same cycle.
- R6: Code 16 (heads) is true when `rand_bit` is 1. Code 17 (tails) is true when it is 0. Either code with `eval_en` high raises `rand_step` for that cycle.
- R7: Code 1 is always true. Code 0 and codes 26 to 31 are always false.
- R8: Codes 18 to 21 compare the tested bits (`bio_mask`) against the match results (`bio_match`), and all four are false while `bio_valid` is low. Code 18 is true when no tested bit missed. Code 19 is true when no tested bit matched. Code 20 is true when some tested bit matched. Code 21 is true when some tested bit missed. With an empty mask, codes 18 and 19 are true and codes 20 and 21 are false.
- R9: Code 22 is true when `bmu_odd` is set and code 23 when it is clear. Code 24 is true when `bmu_neg1` is set and code 25 when it is clear.
- R10: With `eval_en` low, or with a code outside 12 to 17, no strobe is raised and neither counter changes unless it is loaded. At most one strobe is high in any cycle.
- R11: While `rst_n` is low, both counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_en | input | 1 | The selected condition is being evaluated |
| cond_sel | input | 5 | Condition code |
| flag_neg | input | 1 | Result negative flag |
| flag_zero | input | 1 | Result zero flag |
| flag_lovf | input | 1 | Logical overflow flag |
| flag_movf | input | 1 | Mathematical overflow flag |
| rand_bit | input | 1 | Current pseudorandom bit |
| bio_valid | input | 1 | Port compare results are valid |
| bio_mask | input | BW (4) | Bits taking part in the compare |
| bio_match | input | BW (4) | Per-bit compare success |
| bmu_odd | input | 1 | Last bit-manipulation result had odd parity |
| bmu_neg1 | input | 1 | Last bit-manipulation result was minus one |
| ld0 | input | 1 | Load counter 0 |
| ld1 | input | 1 | Load counter 1 |
| ld_val | input | CW (16) | Counter load value |
| cond_true | output | 1 | Condition holds |
| cnt_inc | output | 2 | Counter increment strobes |
| rand_step | output | 1 | Pseudorandom generator step request |
| cnt0 | output | CW (16) | Counter 0 value |
| cnt1 | output | CW (16) | Counter 1 value |

## Verification
`cond_true`, `cnt_inc` and `rand_step` depend only on the inputs and the current counter values. They are due in the same cycle as the stimulus. The counters change one clock edge later. The bench drives inputs on the falling edge and samples the combinational results 1 ns afterwards. It compares the counters against its own model just after the following rising edge. The counter cases include the wrap from most-positive to most-negative, a load that collides with an increment, and a test made with `eval_en` low.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int CW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval_en,
  input  logic [4:0]    cond_sel,
  input  logic          flag_neg,
  input  logic          flag_zero,
  input  logic          flag_lovf,
  input  logic          flag_movf,
  input  logic          rand_bit,
  input  logic          bio_valid,
  input  logic [BW-1:0] bio_mask,
  input  logic [BW-1:0] bio_match,
  input  logic          bmu_odd,
  input  logic          bmu_neg1,
  input  logic          ld0,
  input  logic          ld1,
  input  logic [CW-1:0] ld_val,
  output logic          cond_true,
  output logic [1:0]    cnt_inc,
  output logic          rand_step,
  output logic [CW-1:0] cnt0,
  output logic [CW-1:0] cnt1
);
  localparam logic [4:0] C_FALSE = 5'd0,  C_TRUE  = 5'd1,  C_PL    = 5'd2,  C_MI    = 5'd3,
                         C_EQ    = 5'd4,  C_NE    = 5'd5,  C_GT    = 5'd6,  C_LE    = 5'd7,
                         C_LVS   = 5'd8,  C_LVC   = 5'd9,  C_MVS   = 5'd10, C_MVC   = 5'd11,
                         C_C0GE  = 5'd12, C_C0LT  = 5'd13, C_C1GE  = 5'd14, C_C1LT  = 5'd15,
                         C_HEADS = 5'd16, C_TAILS = 5'd17, C_ALLT  = 5'd18, C_ALLF  = 5'd19,
                         C_SOMET = 5'd20, C_SOMEF = 5'd21, C_ODD   = 5'd22, C_EVEN  = 5'd23,
                         C_M1    = 5'd24, C_NM1   = 5'd25;

  logic [BW-1:0] hit, miss;
  logic          c0_neg, c1_neg;

  assign hit    = bio_mask & bio_match;
  assign miss   = bio_mask & ~bio_match;
  assign c0_neg = cnt0[CW-1];
  assign c1_neg = cnt1[CW-1];

  always_comb begin
    unique case (cond_sel)
      C_TRUE:  cond_true = 1'b1;
      C_PL:    cond_true = !flag_neg;
      C_MI:    cond_true = flag_neg;
      C_EQ:    cond_true = flag_zero;
      C_NE:    cond_true = !flag_zero;
      C_GT:    cond_true = !flag_neg && !flag_zero;
      C_LE:    cond_true = flag_neg || flag_zero;
      C_LVS:   cond_true = flag_lovf;
      C_LVC:   cond_true = !flag_lovf;
      C_MVS:   cond_true = flag_movf;
      C_MVC:   cond_true = !flag_movf;
      C_C0GE:  cond_true = !c0_neg;
      C_C0LT:  cond_true = c0_neg;
      C_C1GE:  cond_true = !c1_neg;
      C_C1LT:  cond_true = c1_neg;
      C_HEADS: cond_true = rand_bit;
      C_TAILS: cond_true = !rand_bit;
      C_ALLT:  cond_true = bio_valid && (miss == '0);
      C_ALLF:  cond_true = bio_valid && (hit == '0);
      C_SOMET: cond_true = bio_valid && (hit != '0);
      C_SOMEF: cond_true = bio_valid && (miss != '0);
      C_ODD:   cond_true = bmu_odd;
      C_EVEN:  cond_true = !bmu_odd;
      C_M1:    cond_true = bmu_neg1;
      C_NM1:   cond_true = !bmu_neg1;
      default: cond_true = 1'b0;
    endcase
  end

  assign cnt_inc[0] = eval_en && (cond_sel == C_C0GE || cond_sel == C_C0LT);
  assign cnt_inc[1] = eval_en && (cond_sel == C_C1GE || cond_sel == C_C1LT);
  assign rand_step  = eval_en && (cond_sel == C_HEADS || cond_sel == C_TAILS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else begin
      if (ld0)             cnt0 <= ld_val;
      else if (cnt_inc[0]) cnt0 <= cnt0 + 1'b1;
      if (ld1)             cnt1 <= ld_val;
      else if (cnt_inc[1]) cnt1 <= cnt1 + 1'b1;
    end
  end
endmodule

// File: rtl/cond_eval_chk.sv
module cond_eval_chk #(
  parameter int CW = 16,
  parameter int BW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eval_en,
  input logic [4:0]    cond_sel,
  input logic          ld0,
  input logic          ld1,
  input logic [CW-1:0] ld_val,
  input logic          cond_true,
  input logic [1:0]    cnt_inc,
  input logic          rand_step,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1
);
  // R4
  cnt0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && (cond_sel == 5'd12 || cond_sel == 5'd13) && !ld0) |=> cnt0 == $past(cnt0) + 1'b1);
  // R4
  cnt1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && (cond_sel == 5'd14 || cond_sel == 5'd15) && !ld1) |=> cnt1 == $past(cnt1) + 1'b1);
  // R5
  cnt0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld0 |=> cnt0 == $past(ld_val));
  // R5
  cnt1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld1 |=> cnt1 == $past(ld_val));
  // R10
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |-> (cnt_inc == 2'b00 && !rand_step));
  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_inc, rand_step}));
  // R10
  cnt0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld0 && !cnt_inc[0]) |=> $stable(cnt0));
  // R7
  unused_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel >= 5'd26 || cond_sel == 5'd0) |-> !cond_true);
endmodule

bind cond_eval cond_eval_chk #(.CW(CW), .BW(BW)) u_chk (.*);

// File: tb/sim_cond_eval.sv
`timescale 1ns/1ps
module sim_cond_eval;
  localparam int CW = 16;
  localparam int BW = 4;

  logic clk = 1'b0, rst_n = 1'b0, eval_en = 1'b0;
  logic [4:0] cond_sel = '0;
  logic flag_neg = 0, flag_zero = 0, flag_lovf = 0, flag_movf = 0, rand_bit = 0;
  logic bio_valid = 0, bmu_odd = 0, bmu_neg1 = 0, ld0 = 0, ld1 = 0;
  logic [BW-1:0] bio_mask = '0, bio_match = '0;
  logic [CW-1:0] ld_val = '0;
  logic cond_true, rand_step;
  logic [1:0] cnt_inc;
  logic [CW-1:0] cnt0, cnt1;
  logic [CW-1:0] m0 = '0, m1 = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cond_eval u0 (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s sel=%0d actual=%0h expected=%0h", req, cond_sel, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] s);
    if (s >= 2 && s <= 7) return "R1";
    if (s >= 8 && s <= 11) return "R2";
    if (s >= 12 && s <= 15) return "R3";
    if (s == 16 || s == 17) return "R6";
    if (s >= 18 && s <= 21) return "R8";
    if (s >= 22 && s <= 25) return "R9";
    return "R7";
  endfunction

  function automatic logic exp_cond();
    logic [BW-1:0] h, mi;
    h = bio_mask & bio_match;
    mi = bio_mask & ~bio_match;
    case (cond_sel)
      1: return 1;
      2: return !flag_neg;
      3: return flag_neg;
      4: return flag_zero;
      5: return !flag_zero;
      6: return !flag_neg && !flag_zero;
      7: return flag_neg || flag_zero;
      8: return flag_lovf;
      9: return !flag_lovf;
      10: return flag_movf;
      11: return !flag_movf;
      12: return $signed(m0) >= 0;
      13: return $signed(m0) < 0;
      14: return $signed(m1) >= 0;
      15: return $signed(m1) < 0;
      16: return rand_bit;
      17: return !rand_bit;
      18: return bio_valid && mi == 0;
      19: return bio_valid && h == 0;
      20: return bio_valid && h != 0;
      21: return bio_valid && mi != 0;
      22: return bmu_odd;
      23: return !bmu_odd;
      24: return bmu_neg1;
      25: return !bmu_neg1;
      default: return 0;
    endcase
  endfunction

  // Inputs are already driven at the falling edge; check same-cycle results, then advance the model.
  task automatic step();
    logic e0, e1, er;
    #1;
    e0 = eval_en && (cond_sel == 12 || cond_sel == 13);
    e1 = eval_en && (cond_sel == 14 || cond_sel == 15);
    er = eval_en && (cond_sel == 16 || cond_sel == 17);
    chk(req_of(cond_sel), cond_true, exp_cond());
    chk("R4/R10 cnt_inc", cnt_inc, {e1, e0});
    chk("R6/R10 rand_step", rand_step, er);
    if (ld0) m0 = ld_val; else if (e0) m0 = m0 + 1'b1;
    if (ld1) m1 = ld_val; else if (e1) m1 = m1 + 1'b1;
    @(posedge clk); #1;
    chk("R4/R5 cnt0", cnt0, m0);
    chk("R4/R5 cnt1", cnt1, m1);
    @(negedge clk);
  endtask

  task automatic drive(input logic [4:0] s, input logic en);
    cond_sel = s; eval_en = en; ld0 = 0; ld1 = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ld0 = 1; ld1 = 1; ld_val = 16'h1234;
    repeat (3) @(posedge clk);
    #1;
    // R11
    chk("R11 cnt0 reset", cnt0, 0);
    chk("R11 cnt1 reset", cnt1, 0);
    @(negedge clk);
    rst_n = 1; ld0 = 0; ld1 = 0;

    // R4 wrap 0x7FFF -> 0x8000 with R3 pre-increment compare
    ld0 = 1; ld_val = 16'h7FFF; drive(5'd12, 1); ld0 = 1;
    step();
    drive(5'd12, 1); step();
    chk("R3 c0ge after wrap", cond_true, 0);
    drive(5'd13, 1); step();
    // R4 wrap 0xFFFF -> 0x0000 on counter 1
    drive(5'd15, 0); ld1 = 1; ld_val = 16'hFFFF; step();
    drive(5'd15, 1); step();
    chk("R4 cnt1 wrapped", cnt1, 0);
    // R5 load collides with increment
    drive(5'd14, 1); ld1 = 1; ld_val = 16'h0055; step();
    chk("R5 load wins", cnt1, 16'h0055);
    // R10 counter test with eval_en low leaves counter alone
    drive(5'd12, 0); step();
    drive(5'd16, 0); rand_bit = 1; step();
    // R7 unused codes and fixed codes
    for (int s = 26; s < 32; s++) begin drive(s[4:0], 1); step(); end
    drive(5'd0, 1); step();
    drive(5'd1, 1); step();
    // R8 empty mask and invalid compare
    bio_valid = 1; bio_mask = 0; bio_match = 4'hF;
    for (int s = 18; s < 22; s++) begin drive(s[4:0], 1); step(); end
    bio_valid = 0; bio_mask = 4'hF;
    for (int s = 18; s < 22; s++) begin drive(s[4:0], 1); step(); end

    for (int i = 0; i < 3000; i++) begin
      cond_sel = 5'($urandom_range(0, 31));
      eval_en = $urandom_range(0, 3) != 0;
      {flag_neg, flag_zero, flag_lovf, flag_movf} = 4'($urandom);
      {rand_bit, bio_valid, bmu_odd, bmu_neg1} = 4'($urandom);
      bio_mask = BW'($urandom); bio_match = BW'($urandom);
      ld0 = $urandom_range(0, 7) == 0;
      ld1 = $urandom_range(0, 7) == 0;
      case ($urandom_range(0, 3))
        0: ld_val = 16'h7FFF;
        1: ld_val = 16'hFFFE;
        default: ld_val = 16'($urandom);
      endcase
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule